// File: doc/BRIEF.md
# Level-Sensitive Interrupt Mask Controller

This block gathers 32 level-sensitive interrupt request lines into one interrupt output for a processor. Each request line is brought into the local clock domain through a two-flop synchroniser. A per-line enable vector then gates the synchronised line. Software sees two views of the lines over a simple 32-bit register bus. The first view is the raw state of every line. The second is the pending state, which is the raw state ANDed with the enables.

The enable vector has no direct read or write register. Software changes it only through two write-one addresses. One sets enable bits and the other clears them, so no read-modify-write is needed and a single all-ones write disables every line. No acknowledge register exists. A pending bit clears only when its source drops the line or when the line is masked.

Besides the combined interrupt, the block reports the index of the lowest-numbered pending line, together with a valid flag. An interrupt handler can use this index to pick its next service target without scanning the word.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset every enable bit is 0. The pending word reads 0, `irq_out` is low and `lowest_vld` is low.
- R2: A read of offset 0x4 returns each line's level as it was sampled two rising clock edges earlier, whatever the enable state. Bit n corresponds to request line n.
- R3: A read of offset 0x0 returns the raw word ANDed with the enable vector.
- R4: A write to offset 0x8 sets the enable bit of every line whose data bit is 1. Lines whose data bit is 0 keep their enable bit. The new enable takes effect from the next clock edge.
- R5: A write to offset 0xC clears the enable bit of every line whose data bit is 1, and leaves the other lines unchanged. Writing all ones clears every enable bit.
- R6: A pending bit stays set on every cycle for as long as its line is held active and enabled. There is no acknowledge operation.
- R7: `irq_out` equals the OR of the pending word as it stood one clock edge earlier.
- R8: Reads of offsets 0x8 and 0xC return 0. Writes to offsets 0x0 and 0x4 leave the enable vector unchanged.
- R9: `lowest_vld` is high exactly when the pending word is non-zero. While it is high, `lowest_idx` gives the position of the lowest set pending bit.
- R10: `bus_rdata` is 0 in any cycle where `bus_re` is low. Address bits [1:0] are ignored during decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive request lines, asynchronous to clk |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from address and strobe |
| irq_out | output | 1 | Registered combined interrupt |
| lowest_idx | output | 5 | Index of the lowest pending line |
| lowest_vld | output | 1 | High when any line is pending |

## Verification
The assertions check several relations on every cycle:
- the set and clear effects of each enable write;
- that writes to the status offsets do not change the enable vector;
- that the priority index points at a pending bit with no lower bit pending;
- that the combined output follows the valid flag one edge later.

Other behaviours can only be shown by the bench's scenarios:
- the two-edge synchroniser latency;
- persistence of a held level over many cycles;
- the reset state;
- zero reads from the write-only offsets.

The bench's cycle-by-cycle model covers these scenarios under directed and pseudo-random input patterns.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int N_LINES = 32,
  parameter int AW      = 4,
  localparam int IW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic [N_LINES-1:0] bus_wdata,
  input  logic               bus_re,
  output logic [N_LINES-1:0] bus_rdata,
  output logic               irq_out,
  output logic [IW-1:0]      lowest_idx,
  output logic               lowest_vld
);

  localparam logic [1:0] SEL_PEND  = 2'd0;
  localparam logic [1:0] SEL_RAW   = 2'd1;
  localparam logic [1:0] SEL_SET   = 2'd2;
  localparam logic [1:0] SEL_CLR   = 2'd3;

  logic [N_LINES-1:0] sync_a, sync_b, enable, pending;
  logic [1:0]         sel;
  logic               irq_q;

  assign sel = bus_addr[3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= irq_in;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      enable <= '0;
    else if (bus_we && sel == SEL_SET)
      enable <= enable | bus_wdata;
    else if (bus_we && sel == SEL_CLR)
      enable <= enable & ~bus_wdata;
  end

  assign pending = sync_b & enable;

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (sel)
        SEL_PEND: bus_rdata = pending;
        SEL_RAW:  bus_rdata = sync_b;
        default:  bus_rdata = '0;
      endcase
    end
  end

  always_comb begin
    lowest_idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--)
      if (pending[i]) lowest_idx = IW'(i);
  end

  assign lowest_vld = |pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pending;
  end

  assign irq_out = irq_q;

  logic [N_LINES-1:0] below_idx;
  assign below_idx = (N_LINES'(1) << lowest_idx) - N_LINES'(1);

  p_unmask_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_SET) |=> ((enable & $past(bus_wdata)) == $past(bus_wdata)));

  p_mask_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_CLR) |=> ((enable & $past(bus_wdata)) == '0));

  p_status_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !sel[1]) |=> $stable(enable));

  p_index_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lowest_vld |-> (pending[lowest_idx] && ((pending & below_idx) == '0)));

  p_irq_tracks_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(lowest_vld));

endmodule

// File: tb/test_irq_mask_ctrl.sv
module test_irq_mask_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic [4:0]  lowest_idx;
  logic        lowest_vld;

  irq_mask_ctrl i_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .lowest_idx(lowest_idx),
    .lowest_vld(lowest_vld)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "";

  logic [31:0] hist[$];
  logic [31:0] m_en;
  logic        m_irq;

  function automatic logic [31:0] m_raw();
    return (hist.size() >= 2) ? hist[1] : 32'h0;
  endfunction

  function automatic logic [31:0] m_pend();
    return m_raw() & m_en;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {32'h0, 32'h0};
      m_en = '0;
      m_irq = 1'b0;
    end else begin
      m_irq = |m_pend();
      if (bus_we && bus_addr[3:2] == 2'd2) m_en = m_en | bus_wdata;
      if (bus_we && bus_addr[3:2] == 2'd3) m_en = m_en & ~bus_wdata;
      hist.push_front(irq_in);
      while (hist.size() > 2) void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] exp_rd, p;
      string rt;
      int lo;
      p = m_pend();
      exp_rd = 32'h0;
      rt = "R10";
      if (bus_re) begin
        case (bus_addr[3:2])
          2'd0: begin exp_rd = p; rt = "R3"; end
          2'd1: begin exp_rd = m_raw(); rt = "R2"; end
          default: begin exp_rd = 32'h0; rt = "R8"; end
        endcase
      end
      if (tag != "") rt = tag;
      check(bus_rdata === exp_rd, rt, bus_rdata, exp_rd);
      check(irq_out === m_irq, "R7", {31'h0, irq_out}, {31'h0, m_irq});
      lo = -1;
      for (int i = 31; i >= 0; i--) if (p[i]) lo = i;
      check(lowest_vld === (lo >= 0), "R9", {31'h0, lowest_vld}, {31'h0, lo >= 0});
      if (lo >= 0) check(lowest_idx === 5'(lo), "R9", {27'h0, lowest_idx}, 32'(lo));
    end
  end

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_re = 1'b0;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input string t, input int n = 1);
    tag = t; bus_re = 1'b1; bus_addr = a;
    tick(n);
    bus_re = 1'b0; tag = "";
  endtask

  initial begin
    #5000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    irq_in = 32'hFFFF_FFFF;
    #23;
    // R1: reset state with all lines active
    bus_re = 1'b1; bus_addr = 4'h0; #1;
    check(bus_rdata === 32'h0, "R1", bus_rdata, 32'h0);
    check(irq_out === 1'b0, "R1", {31'h0, irq_out}, 32'h0);
    check(lowest_vld === 1'b0, "R1", {31'h0, lowest_vld}, 32'h0);
    bus_re = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    tick(3);
    rd(4'h0, "R1", 2);
    // R2: raw view with all masked
    irq_in = 32'hA5A5_0F0F; rd(4'h4, "R2", 4);
    irq_in = 32'h1234_5678; rd(4'h5, "R2", 3);
    // R4: unmask sets only ones
    irq_in = 32'hFFFF_FFFF; tick(2);
    wr(4'h8, 32'h0000_00F0); rd(4'h0, "R4", 2);
    wr(4'h8, 32'h8000_0001); rd(4'h0, "R4", 2);
    // R5: mask clears only ones, then all-ones write
    wr(4'hC, 32'h0000_0030); rd(4'h0, "R5", 2);
    wr(4'hC, 32'hFFFF_FFFF); rd(4'h0, "R5", 2);
    // R6: held level remains pending
    irq_in = 32'h0; wr(4'h8, 32'h0000_0080);
    irq_in = 32'h0000_0080; rd(4'h0, "R6", 12);
    irq_in = 32'h0; rd(4'h0, "R6", 4);
    // R8: write-only offsets read zero, status writes ignored
    irq_in = 32'hFFFF_FFFF; tick(2);
    rd(4'h8, "R8", 2); rd(4'hC, "R8", 2);
    wr(4'h0, 32'hFFFF_FFFF); wr(4'h4, 32'hFFFF_FFFF); rd(4'h0, "R8", 2);
    wr(4'h0, 32'h0); wr(4'h4, 32'h0); rd(4'h0, "R8", 2);
    // R9: lowest index boundaries
    wr(4'h8, 32'hFFFF_FFFF);
    irq_in = 32'h8000_0000; tick(3);
    irq_in = 32'h8000_0001; tick(3);
    irq_in = 32'h0001_0100; tick(3);
    // R10: read strobe low gives zero
    bus_addr = 4'h4; tick(3);
    // R7 and all views under pseudo-random activity
    lf = 32'hC0FF_EE11;
    for (int k = 0; k < 400; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      irq_in = lf & {lf[15:0], lf[31:16]};
      bus_addr = {lf[7:6], lf[1:0]};
      bus_re = lf[9];
      bus_we = lf[10] & lf[11];
      bus_wdata = {lf[3:0], lf[31:4]} & {lf[20:0], lf[31:21]};
      tick();
    end
    bus_we = 1'b0; bus_re = 1'b0;
    tick(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule